// File: doc/BRIEF.md
# Fractional-Rate Clock Generator Bank

This block holds four independent phase-accumulator clock sources that run in the core clock domain. Each source keeps a 32-bit increment and a 32-bit accumulator. While the source is running, the accumulator adds the increment on every core cycle, and the top bit of the accumulator is the generated clock. The output frequency is therefore the core frequency times the increment divided by 2^32. An increment of zero stops the source. The largest increment accepted is 2^31-1, which keeps the output at or below half the core rate.

A set of output pins sits beside the sources. Each pin has a 2-bit select that picks one of the four sources. A pin carries the chosen generated clock only when both its clock-mode bit and its output enable are high. In every other case the pin carries its ordinary data bit. Software or a register block writes one increment per cycle through a single write port, addressed by source index.

Each source has a two-state controller with the states HALTED and RUNNING:
- START moves HALTED to RUNNING when a nonzero increment is written.
- STOP moves RUNNING to HALTED when zero is written.
- RETUNE keeps RUNNING when a different nonzero increment is written.
- In HALTED the accumulator keeps its value and the output is held low.

Each pin route takes one of two values: ROUTE_DATA or ROUTE_CLOCK.

Top module: `fracclk_bank`

## Requirements
- R1: While reset is active and after it is released, every accumulator and increment is zero, every source is HALTED, `gen_clk` is all zeros, and each `pin_out` bit equals its `pin_data` bit unless that pin is routed to a clock.
- R2: A RUNNING source adds its increment to its accumulator on every rising clock edge, and its `gen_clk` bit equals the accumulator's bit 31. For example, increment 0x20000000 gives a period of 8 cycles with 50% duty.
- R3: Writing increment 0 moves the source to HALTED at that edge. From then on the accumulator holds its value and `gen_clk` is low. A later nonzero write resumes counting from the held phase.
- R4: A written increment is registered at the write edge and is first added at the following edge. The accumulator is not cleared, and the edge that registers the write still adds the previous increment.
- R5: A written value with bit 31 set is stored as 0x7FFFFFFF.
- R6: A write addressed by `cfg_idx` changes only that source's increment and state. The other sources are unaffected.
- R7: Pin p reads its select from `pin_gen_sel[2p+1:2p]`, and a select value k picks source k.
- R8: `pin_out[p]` carries the selected `gen_clk` only when both `pin_clk_mode[p]` and `pin_oe[p]` are 1. Otherwise it equals `pin_data[p]`, combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Increment write strobe |
| cfg_idx | input | 2 | Index of the source being written |
| cfg_incr | input | 32 | Increment value to write |
| pin_clk_mode | input | 8 | Per-pin clock-mode bit |
| pin_oe | input | 8 | Per-pin output enable |
| pin_gen_sel | input | 16 | Per-pin source select, 2 bits per pin |
| pin_data | input | 8 | Per-pin normal data bit |
| gen_clk | output | 4 | Generated clock of each source |
| pin_out | output | 8 | Per-pin output value |

## Verification
An increment write and the accumulation step of the same source fall on the same clock edge. That edge must add the old increment and register the new one. The bench provokes this by retuning a running source and by stopping and then restarting one. In the same cycles other pins keep toggling, so the collision is visible at the pins. A cycle-level reference model in the bench applies the accumulate-then-load order at each edge and predicts `gen_clk` and `pin_out`. The scoreboard compares the outputs against the model after every edge, so one cycle of phase slip fails a check.

// File: rtl/fracclk_pkg.sv
package fracclk_pkg;

    typedef enum logic [0:0] {
        GEN_HALTED  = 1'b0,
        GEN_RUNNING = 1'b1
    } gen_state_t;

    typedef enum logic [0:0] {
        ROUTE_DATA  = 1'b0,
        ROUTE_CLOCK = 1'b1
    } pin_route_t;

endpackage

// File: rtl/fracclk_gen.sv
module fracclk_gen
    import fracclk_pkg::*;
#(
    parameter int ACC_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [ACC_W-1:0] wr_val,
    output logic             tone_o,
    output logic             run_o,
    output logic [ACC_W-1:0] acc_o,
    output logic [ACC_W-1:0] inc_o
);

    localparam logic [ACC_W-1:0] INC_MAX = {1'b0, {(ACC_W-1){1'b1}}};

    gen_state_t       state_q;
    gen_state_t       state_d;
    logic [ACC_W-1:0] inc_q;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] wr_capped;
    logic             wr_zero;

    // Values above the legal ceiling are stored as the ceiling.
    assign wr_capped = wr_val[ACC_W-1] ? INC_MAX : wr_val;
    assign wr_zero   = (wr_capped == '0);

    // Next-state logic. START, STOP and RETUNE are the named transitions.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GEN_HALTED: begin
                if (wr_en && !wr_zero) state_d = GEN_RUNNING;   // START
            end
            GEN_RUNNING: begin
                if (wr_en && wr_zero) state_d = GEN_HALTED;     // STOP
                // RETUNE: a nonzero write keeps RUNNING
            end
            default: state_d = GEN_HALTED;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GEN_HALTED;
        else        state_q <= state_d;
    end

    // Increment register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     inc_q <= '0;
        else if (wr_en) inc_q <= wr_capped;
    end

    // Accumulator: it advances with the increment held before this edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       acc_q <= '0;
        else if (state_q == GEN_RUNNING)  acc_q <= acc_q + inc_q;
    end

    // Output process.
    always_comb begin
        unique case (state_q)
            GEN_RUNNING: tone_o = acc_q[ACC_W-1];
            default:     tone_o = 1'b0;
        endcase
        run_o = (state_q == GEN_RUNNING);
        acc_o = acc_q;
        inc_o = inc_q;
    end

endmodule

// File: rtl/fracclk_pin_mux.sv
module fracclk_pin_mux
    import fracclk_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int SEL_W   = 2
) (
    input  logic [NUM_GEN-1:0] tones,
    input  logic [SEL_W-1:0]   sel,
    input  logic               clk_mode,
    input  logic               oe,
    input  logic               data,
    output logic               pin_o
);

    pin_route_t route;

    assign route = (clk_mode && oe) ? ROUTE_CLOCK : ROUTE_DATA;

    always_comb begin
        unique case (route)
            ROUTE_CLOCK: pin_o = tones[sel];
            default:     pin_o = data;
        endcase
    end

endmodule

// File: rtl/fracclk_bank.sv
module fracclk_bank
    import fracclk_pkg::*;
#(
    parameter int NUM_GEN  = 4,
    parameter int ACC_W    = 32,
    parameter int NUM_PINS = 8,
    parameter int SEL_W    = $clog2(NUM_GEN)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cfg_we,
    input  logic [SEL_W-1:0]          cfg_idx,
    input  logic [ACC_W-1:0]          cfg_incr,
    input  logic [NUM_PINS-1:0]       pin_clk_mode,
    input  logic [NUM_PINS-1:0]       pin_oe,
    input  logic [NUM_PINS*SEL_W-1:0] pin_gen_sel,
    input  logic [NUM_PINS-1:0]       pin_data,
    output logic [NUM_GEN-1:0]        gen_clk,
    output logic [NUM_PINS-1:0]       pin_out
);

    logic [NUM_GEN-1:0]            gen_we;
    logic [NUM_GEN-1:0]            gen_run;
    logic [NUM_GEN-1:0][ACC_W-1:0] gen_acc;
    logic [NUM_GEN-1:0][ACC_W-1:0] gen_inc;

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_src
        assign gen_we[g] = cfg_we && (cfg_idx == SEL_W'(g));

        fracclk_gen #(.ACC_W(ACC_W)) u_gen (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (gen_we[g]),
            .wr_val (cfg_incr),
            .tone_o (gen_clk[g]),
            .run_o  (gen_run[g]),
            .acc_o  (gen_acc[g]),
            .inc_o  (gen_inc[g])
        );
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        fracclk_pin_mux #(.NUM_GEN(NUM_GEN), .SEL_W(SEL_W)) u_mux (
            .tones    (gen_clk),
            .sel      (pin_gen_sel[p*SEL_W +: SEL_W]),
            .clk_mode (pin_clk_mode[p]),
            .oe       (pin_oe[p]),
            .data     (pin_data[p]),
            .pin_o    (pin_out[p])
        );
    end

endmodule

// File: rtl/fracclk_bank_chk.sv
module fracclk_bank_chk #(
    parameter int NUM_GEN  = 4,
    parameter int ACC_W    = 32,
    parameter int NUM_PINS = 8,
    parameter int SEL_W    = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      cfg_we,
    input logic [SEL_W-1:0]          cfg_idx,
    input logic [ACC_W-1:0]          cfg_incr,
    input logic [NUM_PINS-1:0]       pin_clk_mode,
    input logic [NUM_PINS-1:0]       pin_oe,
    input logic [NUM_PINS-1:0]       pin_data,
    input logic [NUM_PINS-1:0]       pin_out,
    input logic [NUM_GEN-1:0]        gen_run,
    input logic [NUM_GEN-1:0][ACC_W-1:0] gen_acc,
    input logic [NUM_GEN-1:0][ACC_W-1:0] gen_inc
);

    for (genvar g = 0; g < NUM_GEN; g++) begin : g_gchk
        // R3
        halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !gen_run[g] |=> $stable(gen_acc[g]));

        // R2
        acc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
            gen_run[g] |=> gen_acc[g] == $past(gen_acc[g]) + $past(gen_inc[g]));

        // R5
        inc_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !gen_inc[g][ACC_W-1]);

        // R6
        other_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (!cfg_we || cfg_idx != SEL_W'(g)) |=> $stable(gen_inc[g]) && $stable(gen_run[g]));

        // R3
        zero_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_we && cfg_idx == SEL_W'(g) && cfg_incr == '0) |=> !gen_run[g]);
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pchk
        // R8
        data_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !(pin_clk_mode[p] && pin_oe[p]) |-> pin_out[p] == pin_data[p]);
    end

endmodule

bind fracclk_bank fracclk_bank_chk #(
    .NUM_GEN  (NUM_GEN),
    .ACC_W    (ACC_W),
    .NUM_PINS (NUM_PINS),
    .SEL_W    (SEL_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_we       (cfg_we),
    .cfg_idx      (cfg_idx),
    .cfg_incr     (cfg_incr),
    .pin_clk_mode (pin_clk_mode),
    .pin_oe       (pin_oe),
    .pin_data     (pin_data),
    .pin_out      (pin_out),
    .gen_run      (gen_run),
    .gen_acc      (gen_acc),
    .gen_inc      (gen_inc)
);

// File: tb/fracclk_bank_tb.sv
module fracclk_bank_tb;

    localparam int NG = 4;
    localparam int AW = 32;
    localparam int NP = 8;
    localparam int SW = 2;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cfg_we = 1'b0;
    logic [SW-1:0]   cfg_idx = '0;
    logic [AW-1:0]   cfg_incr = '0;
    logic [NP-1:0]   pin_clk_mode = '0;
    logic [NP-1:0]   pin_oe = '0;
    logic [NP*SW-1:0] pin_gen_sel = '0;
    logic [NP-1:0]   pin_data = '0;
    logic [NG-1:0]   gen_clk;
    logic [NP-1:0]   pin_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    fracclk_bank u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_we       (cfg_we),
        .cfg_idx      (cfg_idx),
        .cfg_incr     (cfg_incr),
        .pin_clk_mode (pin_clk_mode),
        .pin_oe       (pin_oe),
        .pin_gen_sel  (pin_gen_sel),
        .pin_data     (pin_data),
        .gen_clk      (gen_clk),
        .pin_out      (pin_out)
    );

    typedef struct {
        string         tag;
        logic [NG-1:0] g;
        logic [NP-1:0] p;
    } exp_t;

    exp_t exp_q[$];

    // Reference model of the requirements
    logic [AW-1:0] m_inc [NG];
    logic [AW-1:0] m_acc [NG];
    bit            m_run [NG];

    function automatic void model_reset();
        for (int g = 0; g < NG; g++) begin
            m_inc[g] = '0; m_acc[g] = '0; m_run[g] = 0;
        end
    endfunction

    function automatic void model_edge();
        logic [AW-1:0] v;
        if (!rst_n) return;
        for (int g = 0; g < NG; g++) begin
            if (m_run[g]) m_acc[g] = m_acc[g] + m_inc[g];          // R2, R4 old increment
            if (cfg_we && cfg_idx == SW'(g)) begin
                v = cfg_incr[AW-1] ? 32'h7FFF_FFFF : cfg_incr;      // R5
                m_inc[g] = v;
                m_run[g] = (v != '0);                               // R3
            end
        end
    endfunction

    function automatic exp_t model_out(string tag);
        exp_t e;
        e.tag = tag;
        for (int g = 0; g < NG; g++) e.g[g] = m_run[g] && m_acc[g][AW-1];
        for (int p = 0; p < NP; p++)
            e.p[p] = (pin_clk_mode[p] && pin_oe[p]) ? e.g[pin_gen_sel[p*SW +: SW]] : pin_data[p];
        return e;
    endfunction

    task automatic tick(string tag);
        model_edge();
        exp_q.push_back(model_out(tag));
        @(posedge clk);
        @(negedge clk);
        #1;
    endtask

    task automatic run(string tag, int n);
        for (int i = 0; i < n; i++) tick(tag);
    endtask

    task automatic write_inc(string tag, logic [SW-1:0] idx, logic [AW-1:0] val);
        cfg_we = 1'b1; cfg_idx = idx; cfg_incr = val;
        tick(tag);
        cfg_we = 1'b0; cfg_incr = '0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        model_reset();
        run("R1", 3);
        rst_n = 1'b1;
    endtask

    // Monitor: pops and compares after each edge
    always @(negedge clk) begin
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (gen_clk !== e.g || pin_out !== e.p) begin
                errors++;
                $display("FAIL %s at %0t: gen_clk=%b pin_out=%b expected gen_clk=%b pin_out=%b",
                         e.tag, $time, gen_clk, pin_out, e.g, e.p);
            end
        end
    end

    initial begin
        #(200000 * 10);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog (all requirements): actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        @(negedge clk); #1;
        pin_data = 8'hA5;
        do_reset();
        run("R1", 4);

        // R2: single source, period 8
        pin_gen_sel = 16'h0000; pin_clk_mode = 8'h01; pin_oe = 8'h01;
        write_inc("R2", 2'd0, 32'h2000_0000);
        run("R2", 24);

        // R6: set up the others, gen0 must keep its phase
        write_inc("R6", 2'd1, 32'h4000_0000);
        write_inc("R6", 2'd2, 32'h1000_0000);
        write_inc("R6", 2'd3, 32'h0800_0000);
        run("R6", 8);

        // R7: select field per pin, two mappings
        pin_clk_mode = 8'hFF; pin_oe = 8'hFF;
        pin_gen_sel = 16'hE4E4;
        run("R7", 20);
        pin_gen_sel = 16'h1B1B;
        run("R7", 20);

        // R8: only mode AND oe routes the clock
        pin_clk_mode = 8'hF0; pin_oe = 8'h3C; pin_data = 8'h5A;
        run("R8", 12);
        pin_data = 8'hC3;
        run("R8", 6);

        // R4: retune running source mid-phase
        pin_clk_mode = 8'hFF; pin_oe = 8'hFF; pin_gen_sel = 16'hE4E4;
        run("R4", 3);
        write_inc("R4", 2'd0, 32'h6000_0000);
        run("R4", 16);

        // R3: stop, hold, resume from held phase
        run("R3", 1);
        write_inc("R3", 2'd1, 32'h0000_0000);
        run("R3", 10);
        write_inc("R3", 2'd1, 32'h4000_0000);
        run("R3", 10);

        // R5: oversize increments are capped
        write_inc("R5", 2'd2, 32'hFFFF_FFFF);
        run("R5", 12);
        write_inc("R5", 2'd3, 32'h8000_0000);
        run("R5", 12);

        // R1: reset mid-run returns all to idle
        pin_clk_mode = 8'h0F; pin_oe = 8'hFF;
        do_reset();
        run("R1", 6);

        finished = 1;
        @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule